// File: doc/BRIEF.md
# Wake-up Source Collector and Cluster Power-down Gate

This block gathers wake-up events for a two-cluster processor complex and turns them into a single wake request plus one power-down request per cluster. Each CPU interrupt line, a software watchdog event and a generic timer event can set a sticky bit in a 12-bit pending vector. Software picks which pending bits count through a 12-bit mask. The masked result drives the wake output. Each cluster's power-down request is gated by a separate enable bit.

The block also holds one 32-bit warm-boot resume address per CPU. Power-management firmware writes these addresses before it parks a core. All state is reached through a simple single-cycle register port. Writes take effect on the next clock edge. Read data is combinational from the current address.

Top module: `wake_pd_ctrl`

## Requirements
- R1: After reset every register reads 0, `wake_o` is 0 and both `pd_req` bits are 0.
- R2: The wake mask at offset 0xB24 holds 12 bits. Each bit can be written and read back on its own. Write data above bit 11 is dropped, and those bits read as 0.
- R3: A CPU interrupt for cluster c, CPU n sets pending bit 4*c+n. The watchdog event sets bit 10 and the timer event sets bit 11. Bits 8 and 9 have no source and stay 0.
- R4: A pending bit is set in any cycle where its source is high, and it stays set after the source falls. Writing 1 to a bit of the pending register at offset 0xB28 clears that bit. If the source is still high in the same cycle, the set wins.
- R5: The status register at offset 0xB2C reads as pending AND mask. Writes to it change nothing.
- R6: `wake_o` is 1 in the cycle after any status bit is 1, and 0 otherwise.
- R7: The power-down enables for cluster 0 (offset 0xB30) and cluster 1 (offset 0xB34) take bit 0 of the write data and read back in bit 0.
- R8: `pd_req[c]` is 1 only when enable c is 1 and no status bit of cluster c's CPU group or of the global group (bits 10 and 11) is set.
- R9: The resume address for cluster 0, CPU n is a 32-bit register at 0xB68+4*n. For cluster 1, CPU n it is at 0xB78+4*n.
- R10: Reads from unmapped offsets, and any cycle that is not a read, return 0. Writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel=1 and bus_we=0 |
| cpu_irq | input | 2*CPC (8) | Per-CPU interrupt lines, cluster 1 in the upper half |
| wdog_evt | input | 1 | Software watchdog event |
| tmr_evt | input | 1 | Generic timer event |
| wake_o | output | 1 | Registered wake request |
| pd_req | output | 2 | Per-cluster power-down request |

## Verification
The bench uses the default values, CPC=4 and AW=12. With these values all eight per-CPU pending bits, every resume register of both clusters, and the unused bits 8 and 9 can be driven and observed. A behavioural model runs beside the design and is compared every cycle. It checks read data, the wake output and both power-down requests while directed sequences and a long random phase mix source pulses, clears, mask changes and enable changes.

// File: rtl/wake_pd_ctrl.sv
module wake_pd_ctrl #(
  parameter int CPC = 4,
  parameter int AW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [2*CPC-1:0] cpu_irq,
  input  logic            wdog_evt,
  input  logic            tmr_evt,
  output logic            wake_o,
  output logic [1:0]      pd_req
);
  localparam int MW = 12;
  localparam logic [AW-1:0] MASK_A = AW'(12'hB24);
  localparam logic [AW-1:0] RAW_A  = AW'(12'hB28);
  localparam logic [AW-1:0] STAT_A = AW'(12'hB2C);
  localparam logic [AW-1:0] PD0_A  = AW'(12'hB30);
  localparam logic [AW-1:0] PD1_A  = AW'(12'hB34);
  localparam logic [MW-1:0] GLB_G  = 12'hC00;
  localparam logic [MW-1:0] CL0_G  = 12'h00F;
  localparam logic [MW-1:0] CL1_G  = 12'h0F0;

  function automatic logic [AW-1:0] res_addr(input int c, input int n);
    return AW'(((c == 0) ? 32'hB68 : 32'hB78) + 32'(4 * n));
  endfunction

  logic [MW-1:0] mask_q, raw_q, src, status;
  logic [1:0]    pd_en_q;
  logic [31:0]   resume_q [2][CPC];
  logic          wr;

  assign wr = bus_sel && bus_we;

  for (genvar c = 0; c < 2; c++) begin : g_cl
    for (genvar n = 0; n < 4; n++) begin : g_cpu
      if (n < CPC) begin : g_on
        assign src[4*c+n] = cpu_irq[c*CPC+n];
      end else begin : g_off
        assign src[4*c+n] = 1'b0;
      end
    end
  end
  assign src[9:8] = 2'b00;
  assign src[10]  = wdog_evt;
  assign src[11]  = tmr_evt;

  assign status = raw_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      raw_q   <= '0;
      pd_en_q <= '0;
      wake_o  <= 1'b0;
    end else begin
      wake_o <= |status;
      raw_q  <= (raw_q & ~((wr && bus_addr == RAW_A) ? bus_wdata[MW-1:0] : '0)) | src;
      if (wr && bus_addr == MASK_A) mask_q     <= bus_wdata[MW-1:0];
      if (wr && bus_addr == PD0_A)  pd_en_q[0] <= bus_wdata[0];
      if (wr && bus_addr == PD1_A)  pd_en_q[1] <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++)
        for (int n = 0; n < CPC; n++)
          resume_q[c][n] <= '0;
    end else if (wr) begin
      for (int c = 0; c < 2; c++)
        for (int n = 0; n < CPC; n++)
          if (bus_addr == res_addr(c, n)) resume_q[c][n] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        MASK_A:  bus_rdata = 32'(mask_q);
        RAW_A:   bus_rdata = 32'(raw_q);
        STAT_A:  bus_rdata = 32'(status);
        PD0_A:   bus_rdata = {31'd0, pd_en_q[0]};
        PD1_A:   bus_rdata = {31'd0, pd_en_q[1]};
        default: begin
          for (int c = 0; c < 2; c++)
            for (int n = 0; n < CPC; n++)
              if (bus_addr == res_addr(c, n)) bus_rdata = resume_q[c][n];
        end
      endcase
    end
  end

  assign pd_req[0] = pd_en_q[0] && !(|(status & (CL0_G | GLB_G)));
  assign pd_req[1] = pd_en_q[1] && !(|(status & (CL1_G | GLB_G)));
endmodule

// File: rtl/wake_pd_ctrl_sva.sv
module wake_pd_ctrl_sva #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [11:0]   mask_q,
  input logic [11:0]   raw_q,
  input logic [1:0]    pd_en_q,
  input logic [1:0]    pd_req,
  input logic          wake_o
);
  logic wr_raw, wr_stat;
  assign wr_raw  = bus_sel && bus_we && bus_addr == AW'(12'hB28);
  assign wr_stat = bus_sel && bus_we && bus_addr == AW'(12'hB2C);

  a_r6_wake_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wake_o == $past(|(raw_q & mask_q))));

  a_r4_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_raw |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  a_r3_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q[9:8] == 2'b00);

  a_r5_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ($stable(mask_q) && $stable(pd_en_q)));

  a_r8_pd0_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req[0] |-> pd_en_q[0]);

  a_r8_pd1_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req[1] |-> pd_en_q[1]);

  a_r8_global_blocks_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_q & mask_q & 12'hC00)) |-> (pd_req == 2'b00));
endmodule

bind wake_pd_ctrl wake_pd_ctrl_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .mask_q(mask_q), .raw_q(raw_q), .pd_en_q(pd_en_q),
  .pd_req(pd_req), .wake_o(wake_o)
);

// File: tb/sim_wake_pd_ctrl.sv
`timescale 1ns/1ps
module sim_wake_pd_ctrl;
  localparam int CPC = 4;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] cpu_irq = '0;
  logic wdog_evt = 0, tmr_evt = 0, wake_o;
  logic [1:0] pd_req;

  always #4 clk = ~clk;

  wake_pd_ctrl #(.CPC(CPC), .AW(12)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .wdog_evt(wdog_evt), .tmr_evt(tmr_evt),
    .wake_o(wake_o), .pd_req(pd_req));

  int checks = 0, fails = 0;
  bit [11:0] m_mask, m_raw;
  bit [1:0]  m_pd;
  bit [31:0] m_res [2][4];
  bit        m_wake;
  bit        done = 0;

  function automatic int res_slot(input bit [11:0] a);
    for (int c = 0; c < 2; c++)
      for (int n = 0; n < 4; n++)
        if (a == 12'((c == 0 ? 'hB68 : 'hB78) + 4*n)) return c*4+n;
    return -1;
  endfunction

  function automatic bit [31:0] exp_rd();
    int s;
    if (!(bus_sel && !bus_we)) return 0;
    case (bus_addr)
      12'hB24: return {20'd0, m_mask};
      12'hB28: return {20'd0, m_raw};
      12'hB2C: return {20'd0, m_raw & m_mask};
      12'hB30: return {31'd0, m_pd[0]};
      12'hB34: return {31'd0, m_pd[1]};
      default: begin
        s = res_slot(bus_addr);
        return (s < 0) ? 32'd0 : m_res[s/4][s%4];
      end
    endcase
  endfunction

  function automatic string rd_tag();
    if (!(bus_sel && !bus_we)) return "R10";
    case (bus_addr)
      12'hB24: return "R2";
      12'hB28: return "R4";
      12'hB2C: return "R5";
      12'hB30, 12'hB34: return "R7";
      default: return (res_slot(bus_addr) < 0) ? "R10" : "R9";
    endcase
  endfunction

  task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit [11:0] setv, clr;
    bit nwake;
    int s;
    bit [11:0] st;
    if (!rst_n) begin
      m_mask = 0; m_raw = 0; m_pd = 0; m_wake = 0;
      for (int c = 0; c < 2; c++) for (int n = 0; n < 4; n++) m_res[c][n] = 0;
    end else begin
      nwake = (m_raw & m_mask) != 0;
      setv = 0;
      for (int c = 0; c < 2; c++)
        for (int n = 0; n < CPC; n++)
          if (cpu_irq[c*CPC+n]) setv[4*c+n] = 1;
      if (wdog_evt) setv[10] = 1;
      if (tmr_evt)  setv[11] = 1;
      clr = (bus_sel && bus_we && bus_addr == 12'hB28) ? bus_wdata[11:0] : 12'h0;
      m_raw = (m_raw & ~clr) | setv;
      if (bus_sel && bus_we) begin
        if (bus_addr == 12'hB24) m_mask = bus_wdata[11:0];
        if (bus_addr == 12'hB30) m_pd[0] = bus_wdata[0];
        if (bus_addr == 12'hB34) m_pd[1] = bus_wdata[0];
        s = res_slot(bus_addr);
        if (s >= 0) m_res[s/4][s%4] = bus_wdata;
      end
      m_wake = nwake;
    end
    #3;
    if (rst_n && !done) begin
      st = m_raw & m_mask;
      check(rd_tag(), bus_rdata, exp_rd());
      check("R6 wake", {31'd0, wake_o}, {31'd0, m_wake});
      check("R8 pd0", {31'd0, pd_req[0]}, {31'd0, m_pd[0] && (st & 12'hC0F) == 0});
      check("R8 pd1", {31'd0, pd_req[1]}, {31'd0, m_pd[1] && (st & 12'hCF0) == 0});
    end
  end

  task automatic idle(input int n = 1);
    repeat (n) begin @(negedge clk); bus_sel = 0; bus_we = 0; end
  endtask
  task automatic wr(input bit [11:0] a, input bit [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask
  task automatic rd(input bit [11:0] a);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
  endtask
  task automatic read_all();
    foreach (addrs[i]) rd(addrs[i]);
  endtask
  bit [11:0] addrs [13] = '{12'hB24, 12'hB28, 12'hB2C, 12'hB30, 12'hB34,
    12'hB68, 12'hB6C, 12'hB70, 12'hB74, 12'hB78, 12'hB7C, 12'hB80, 12'hB84};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 wake", {31'd0, wake_o}, 0);
    check("R1 pd", {30'd0, pd_req}, 0);
    check("R1 mask", 32'(u0.bus_rdata === 32'd0), 1);
    read_all();
    wr(12'hB24, 32'hFFFF_FFFF); rd(12'hB24);
    wr(12'hB24, 32'h0000_05A5); rd(12'hB24);
    wr(12'hB24, 32'h0000_0000); rd(12'hB24);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); cpu_irq = 8'(1 << b);
      @(negedge clk); cpu_irq = 0;
      rd(12'hB28);
    end
    @(negedge clk); wdog_evt = 1; @(negedge clk); wdog_evt = 0; rd(12'hB28);
    @(negedge clk); tmr_evt = 1;  @(negedge clk); tmr_evt = 0;  rd(12'hB28);
    @(negedge clk); cpu_irq = 8'h01;
    wr(12'hB28, 32'h0000_0003); rd(12'hB28);
    @(negedge clk); cpu_irq = 0;
    wr(12'hB28, 32'h0000_0003); rd(12'hB28);
    wr(12'hB2C, 32'hFFFF_FFFF); rd(12'hB24); rd(12'hB2C);
    wr(12'hB30, 32'h1); wr(12'hB34, 32'hFFFF_FFFF); rd(12'hB30); rd(12'hB34);
    wr(12'hB24, 32'h0000_0010); rd(12'hB2C); idle(2);
    wr(12'hB24, 32'h0000_0400); idle(2);
    wr(12'hB28, 32'h0000_0FFF); idle(2);
    wr(12'hB24, 32'h0000_0004); idle(2);
    wr(12'hB34, 0); idle(2);
    for (int i = 0; i < 8; i++) wr(addrs[5+i], 32'hC0DE_0000 + 32'(i * 32'h1111));
    wr(12'hB40, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF); wr(12'hB88, 32'h1234);
    read_all(); rd(12'hB40); rd(12'h000); rd(12'hB88);
    for (int i = 0; i < 3000; i++) begin
      int k;
      @(negedge clk);
      cpu_irq  = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
      wdog_evt = ($urandom % 16 == 0);
      tmr_evt  = ($urandom % 16 == 0);
      k = $urandom % 20;
      bus_sel = ($urandom % 2) == 1;
      bus_we  = ($urandom % 2) == 1;
      bus_addr = (k < 13) ? addrs[k] : 12'($urandom);
      bus_wdata = $urandom;
    end
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule